// File: doc/BRIEF.md
# Dual-Mode Serial Command Receiver

This block is a write-only serial slave that takes command bytes from a host controller. It accepts two framing styles on the same receiver. In the three-wire style, a separate enable line marks where a frame begins and ends, and SDA carries only data. In the two-wire style the enable input is tied to SDA, and the usual I2C start and stop conditions on SDA frame the transfer. All three bus lines are oversampled with a fast system clock. The block does not run in the SCL clock domain.

After a start, the receiver collects an address byte and compares it with its own device address. One bit of that address comes from a strap input. If the address matches, the receiver acknowledges that byte and every data byte that follows, and hands each data byte to the core logic with a single-cycle strobe. A frame carries any number of data bytes and ends with a stop. A repeated start at any point restarts address reception.

Top module: `cmd_rx_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_pull_o` and `data_valid_o` are both 0.
- R2: In three-wire mode, a falling edge of `sen_i` while SCL is high starts a frame. A rising edge of `sen_i` while SCL is high is a stop.
- R3: With `sen_i` tied to SDA, a falling edge of SDA while SCL is high starts a frame. A rising edge of SDA while SCL is high is a stop.
- R4: The first byte after a start is the address. It is taken MSB first on SCL rising edges and accepted only when it equals 1,0,0,0,1,0,A,0 (MSB to LSB). A is `addr_sel_i`, and the final 0 is the write flag. An accepted address is acknowledged by holding SDA low for the whole ninth clock.
- R5: If the address mismatches or the write flag is 1, no acknowledge is given and no data strobe occurs before the next start.
- R6: Each data byte after an accepted address appears on `data_o`, MSB first as received, with `data_valid_o` high for exactly one system-clock cycle.
- R7: Each data byte is acknowledged with SDA low for the whole ninth clock. The pull-down is asserted only after an SCL falling edge and is released on the SCL falling edge that ends the acknowledge clock.
- R8: After a stop, bytes clocked without a new start get no acknowledge and no strobe, and a stop leaves the pull-down released.
- R9: A repeated start, whether after an accepted byte or after a rejected address, restarts address reception.
- R10: A frame can carry any number of data bytes. Three bytes in a row are each acknowledged and strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND level) |
| sen_i | input | 1 | Frame enable line; tie to SDA for two-wire mode |
| addr_sel_i | input | 1 | Strap that sets the variable address bit |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| data_o | output | 8 | Last received data byte |
| data_valid_o | output | 1 | One-cycle strobe for a new byte on `data_o` |

## Verification
On every cycle, the checker confirms four things: the data strobe is one cycle wide and follows an SCL rising edge; the pull-down only rises after an SCL falling edge; it only drops after a falling edge, start or stop; and start and stop events leave the pull-down released. Only the bench scenarios can show that the address value and write flag are decoded correctly, that the acknowledge is seen across the whole ninth clock, and that the byte values are right. The same holds for rejected frames, bytes sent after a stop, and repeated starts in both framing styles.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CNT_W  = 4;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_ADDR,
      FR_DATA,
      FR_SKIP
   } frame_st_t;
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   for (genvar g = 0; g < WIDTH; g++) begin : g_line
      logic [STAGES-1:0] chain;
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= din[g];
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
         end
      end
      assign dout[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/cmdrx_events.sv
module cmdrx_events #(
   parameter bit USE_ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   input  logic sen_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_q, sda_q, sen_q;
   logic scl_held;
   logic sda_dn, sda_up, sen_dn, sen_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
         sen_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         sen_q <= sen_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign scl_held = scl_s & scl_q;
   assign sda_dn   = sda_q & ~sda_s;
   assign sda_up   = ~sda_q & sda_s;
   assign sen_dn   = sen_q & ~sen_s;
   assign sen_up   = ~sen_q & sen_s;

   if (USE_ENABLE) begin : g_dual
      assign start_evt = scl_held & (sda_dn | sen_dn);
      assign stop_evt  = scl_held & (sda_up | sen_up);
   end else begin : g_twowire
      logic unused_sen;
      assign unused_sen = sen_dn | sen_up;
      assign start_evt  = scl_held & sda_dn;
      assign stop_evt   = scl_held & sda_up;
   end
endmodule

// File: rtl/cmdrx_frame.sv
module cmdrx_frame
   import cmdrx_pkg::*;
#(
   parameter logic [6:0]  DEV_ID  = 7'b1000100,
   parameter int unsigned SEL_POS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              sda_bit,
   input  logic              addr_sel,
   output logic              pull,
   output logic [BYTE_W-1:0] data,
   output logic              valid
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(BYTE_W + 1);

   frame_st_t         st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sr;
   logic [BYTE_W-1:0] full;
   logic [BYTE_W-1:0] own_addr;
   logic              ack_pend;
   logic              active;

   always_comb begin
      own_addr          = {DEV_ID, 1'b0};
      own_addr[SEL_POS] = addr_sel;
   end

   assign full   = {sr[BYTE_W-2:0], sda_bit};
   assign active = (st == FR_ADDR) || (st == FR_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FR_IDLE;
         cnt      <= '0;
         sr       <= '0;
         data     <= '0;
         valid    <= 1'b0;
         pull     <= 1'b0;
         ack_pend <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (start_evt) begin
            st       <= FR_ADDR;
            cnt      <= '0;
            pull     <= 1'b0;
            ack_pend <= 1'b0;
         end else if (stop_evt) begin
            st       <= FR_IDLE;
            cnt      <= '0;
            pull     <= 1'b0;
            ack_pend <= 1'b0;
         end else if (active) begin
            if (scl_rise && cnt < ACK_END) begin
               cnt <= cnt + 1'b1;
               if (cnt < ACK_SLOT) sr <= full;
               if (cnt == LAST_BIT) begin
                  if (st == FR_ADDR) begin
                     if (full == own_addr) begin
                        st       <= FR_DATA;
                        ack_pend <= 1'b1;
                     end else begin
                        st <= FR_SKIP;
                     end
                  end else begin
                     data     <= full;
                     valid    <= 1'b1;
                     ack_pend <= 1'b1;
                  end
               end
            end
            if (scl_fall) begin
               if (cnt == ACK_SLOT) begin
                  pull <= ack_pend;
               end else if (cnt == ACK_END) begin
                  pull     <= 1'b0;
                  cnt      <= '0;
                  ack_pend <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/cmd_rx_slave.sv
module cmd_rx_slave
   import cmdrx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          USE_ENABLE  = 1'b1,
   parameter logic [6:0]  DEV_ID      = 7'b1000100,
   parameter int unsigned SEL_POS     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              sen_i,
   input  logic              addr_sel_i,
   output logic              sda_pull_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              data_valid_o
);
   localparam int unsigned LINES = 3;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("cmd_rx_slave: SYNC_STAGES must be at least 2");
   end
   if (SEL_POS < 1 || SEL_POS > BYTE_W - 1) begin : g_chk_sel
      $error("cmd_rx_slave: SEL_POS must address a bit above the write flag");
   end

   logic [LINES-1:0] raw_lines;
   logic [LINES-1:0] sync_lines;
   logic scl_sync, sda_sync, sen_sync;
   logic scl_rise, scl_fall, start_evt, stop_evt;

   assign raw_lines = {sen_i, sda_i, scl_i};
   assign {sen_sync, sda_sync, scl_sync} = sync_lines;

   cmdrx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines),
      .dout (sync_lines)
   );

   cmdrx_events #(.USE_ENABLE(USE_ENABLE)) u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_sync),
      .sda_s    (sda_sync),
      .sen_s    (sen_sync),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt)
   );

   cmdrx_frame #(.DEV_ID(DEV_ID), .SEL_POS(SEL_POS)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt),
      .sda_bit  (sda_sync),
      .addr_sel (addr_sel_i),
      .pull     (sda_pull_o),
      .data     (data_o),
      .valid    (data_valid_o)
   );
endmodule

// File: rtl/cmdrx_checker.sv
module cmdrx_checker (
   input logic clk,
   input logic rst_n,
   input logic pull,
   input logic valid,
   input logic scl_rise,
   input logic scl_fall,
   input logic start_evt,
   input logic stop_evt
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !pull && !valid);

   p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   p_valid_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(scl_rise));

   p_pull_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull) |-> $past(scl_fall));

   p_pull_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pull) |-> $past(scl_fall || start_evt || stop_evt));

   p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !pull);

   p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !pull && !valid);
endmodule

bind cmd_rx_slave cmdrx_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pull     (sda_pull_o),
   .valid    (data_valid_o),
   .scl_rise (scl_rise),
   .scl_fall (scl_fall),
   .start_evt(start_evt),
   .stop_evt (stop_evt)
);

// File: tb/cmd_rx_slave_bench.sv
module cmd_rx_slave_bench;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic host_sda = 1'b1;
   logic host_sen = 1'b1;
   logic two_wire = 1'b0;
   logic addr_sel = 1'b0;
   logic sda_line, sen_line;
   logic pull, valid;
   logic [7:0] data;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   assign sda_line = host_sda & ~pull;
   assign sen_line = two_wire ? sda_line : host_sen;

   cmd_rx_slave u_cmd_rx_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_line),
      .sen_i       (sen_line),
      .addr_sel_i  (addr_sel),
      .sda_pull_o  (pull),
      .data_o      (data),
      .data_valid_o(valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic q_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      if (two_wire) begin
         host_sda = 1'b1; q_wait(Q);
         scl = 1'b1;      q_wait(Q);
         host_sda = 1'b0; q_wait(Q);
         scl = 1'b0;      q_wait(Q);
      end else begin
         host_sen = 1'b1; q_wait(Q);
         scl = 1'b1;      q_wait(Q);
         host_sen = 1'b0; q_wait(Q);
         scl = 1'b0;      q_wait(Q);
         host_sen = 1'b1; q_wait(Q);
      end
   endtask

   task automatic do_stop();
      if (two_wire) begin
         host_sda = 1'b0; q_wait(Q);
         scl = 1'b1;      q_wait(Q);
         host_sda = 1'b1; q_wait(Q);
      end else begin
         host_sen = 1'b0; q_wait(Q);
         scl = 1'b1;      q_wait(Q);
         host_sen = 1'b1; q_wait(Q);
      end
      check(pull == 1'b0, "R8 pull after stop", pull, 0);
   endtask

   // Driver: sends one byte MSB first plus an acknowledge clock.
   task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                            input bit is_data, input string req);
      if (is_data && exp_ack) exp_q.push_back(b);
      for (int i = 7; i >= 0; i--) begin
         host_sda = b[i]; q_wait(Q);
         scl = 1'b1;      q_wait(2 * Q);
         scl = 1'b0;      q_wait(Q);
      end
      host_sda = 1'b1; q_wait(Q);
      scl = 1'b1;      q_wait(1);
      check(sda_line == !exp_ack, {req, " ack early in ninth clock"}, sda_line, !exp_ack);
      q_wait(2 * Q - 1);
      check(sda_line == !exp_ack, {req, " ack late in ninth clock"}, sda_line, !exp_ack);
      scl = 1'b0; q_wait(Q);
      check(pull == 1'b0, "R7 release after ack clock", pull, 0);
   endtask

   // Monitor: pops expected bytes as strobes appear.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5/R8 unexpected strobe", data, 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(data == e, "R6 data byte", data, e);
               @(negedge clk);
               check(valid == 1'b0, "R6 strobe width", valid, 0);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      q_wait(3);
      check(pull == 1'b0 && valid == 1'b0, "R1 in reset", {pull, valid}, 0);
      rst_n = 1'b1;
      q_wait(4);
      check(pull == 1'b0 && valid == 1'b0, "R1 after reset", {pull, valid}, 0);

      // R2 R4 R6 R10: three-wire, strap low
      two_wire = 1'b0; addr_sel = 1'b0;
      do_start();
      send_byte(8'h88, 1'b1, 1'b0, "R4 address");
      send_byte(8'h3C, 1'b1, 1'b1, "R2 data");
      send_byte(8'hA5, 1'b1, 1'b1, "R10 data");
      send_byte(8'h00, 1'b1, 1'b1, "R10 data");
      do_stop();

      // R8: bytes after stop without start
      send_byte(8'h88, 1'b0, 1'b0, "R8 address after stop");
      send_byte(8'h77, 1'b0, 1'b0, "R8 byte after stop");

      // R3 R7: two-wire, strap high
      two_wire = 1'b1; addr_sel = 1'b1;
      q_wait(Q);
      do_start();
      send_byte(8'h8A, 1'b1, 1'b0, "R3 address");
      send_byte(8'h01, 1'b1, 1'b1, "R7 data");
      send_byte(8'hFE, 1'b1, 1'b1, "R7 data");
      send_byte(8'h80, 1'b1, 1'b1, "R3 data");
      do_stop();

      // R5: strap mismatch
      do_start();
      send_byte(8'h88, 1'b0, 1'b0, "R5 wrong address");
      send_byte(8'h55, 1'b0, 1'b0, "R5 ignored byte");
      do_stop();

      // R5: read flag set
      do_start();
      send_byte(8'h8B, 1'b0, 1'b0, "R5 read flag");
      send_byte(8'h12, 1'b0, 1'b0, "R5 ignored byte");
      do_stop();

      // R9: repeated start after accepted byte and after a rejection
      do_start();
      send_byte(8'h8A, 1'b1, 1'b0, "R9 address");
      send_byte(8'h11, 1'b1, 1'b1, "R9 data");
      do_start();
      send_byte(8'h8A, 1'b1, 1'b0, "R9 address again");
      send_byte(8'h22, 1'b1, 1'b1, "R9 data");
      do_start();
      send_byte(8'h88, 1'b0, 1'b0, "R9 rejected address");
      do_start();
      send_byte(8'h8A, 1'b1, 1'b0, "R9 address after rejection");
      send_byte(8'h33, 1'b1, 1'b1, "R9 data");
      do_stop();

      // R9 in three-wire mode with strap low
      two_wire = 1'b0; addr_sel = 1'b0;
      q_wait(Q);
      do_start();
      send_byte(8'h88, 1'b1, 1'b0, "R2 address");
      send_byte(8'h5A, 1'b1, 1'b1, "R2 data");
      do_start();
      send_byte(8'h88, 1'b1, 1'b0, "R9 three-wire address");
      send_byte(8'hC3, 1'b1, 1'b1, "R9 three-wire data");
      do_stop();

      q_wait(Q);
      check(exp_q.size() == 0, "R6 all bytes strobed", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule